// File: doc/BRIEF.md
# Privilege-filtered JTAG instruction gate

This block sits between an existing IEEE 1149.1 TAP controller and the debug and test resources of a chip. It holds a protection level from most open (P1) to fully closed (P4). At every Update-IR it checks the instruction the host shifted in against a permission table. A permitted instruction reaches the chip's instruction decoder unchanged. Any other instruction is replaced by BYPASS (all ones), so scan timing on the pins stays exactly as the standard defines it.

The level changes through a dedicated authentication instruction. While that instruction is active, Shift-DR loads a register with a requested level and a credential. Update-DR then applies the request. Moving to a more protected level always succeeds. Moving to a less protected level needs a credential equal to a stored key, compared without early exit. Each failed attempt to lower the level counts toward a lockout that only reset clears. At P4 and during authentication, TDO is held low, so no register content leaves the chip.

Top module: `jtag_access_gate`

## Requirements
- R1: On power-on or while `trst_n` is low, the level is P4 (code 3), `ir_eff` is all ones (BYPASS), `ir_blocked` is 0 and `auth_locked` is 0.
- R2: With the default 4-bit codes, instructions fall into classes as follows: 0xF bypass; 0x1 idcode; 0x0 and 0x2 boundary scan; 0x8 to 0xB debug; 0xC and 0xD flash; 0x7 authentication. Every other code is undefined and is filtered at every level.
- R3: Permitted classes by level (code in brackets): P1 (0) permits all five classes. P2 (1) permits bypass, debug and flash. P3 (2) permits bypass, idcode and boundary scan. P4 (3) permits bypass only.
- R4: On the clock edge where `tap_update_ir` is high, `ir_eff` takes `ir_in` if its class is permitted at the current level. Otherwise `ir_eff` becomes all ones and `ir_blocked` goes to 1. `ir_eff` changes at no other time.
- R5: The authentication code 0x7 passes at every level. While it is effective, Shift-DR shifts `tdi` into an 18-bit register, least significant bit first. After a full shift, bits [1:0] hold the requested level and bits [17:2] hold the credential.
- R6: On Update-DR under authentication, a requested level equal to or higher than the current level takes effect with no credential check, including when locked.
- R7: A requested level lower than the current level takes effect only if the credential equals the stored key and the gate is not locked.
- R8: A failed attempt to lower the level leaves the level unchanged and counts one failure. After 3 failures `auth_locked` is 1, and every later attempt to lower the level is ignored, even with the right key, until reset.
- R9: `tdo_out` equals `dr_tdo_in` except that it is 0 while the level is P4 or while the authentication instruction is effective.
- R10: Every Update-DR under authentication clears the authentication register to zero. An update with no new shift therefore requests P1 with an all-zero credential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset, also used for power-on |
| tap_update_ir | input | 1 | TAP is in Update-IR |
| ir_in | input | 4 | Instruction shift register contents from the TAP |
| tap_shift_dr | input | 1 | TAP is in Shift-DR |
| tap_update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial test data in |
| dr_tdo_in | input | 1 | Serial output of the data register the chip has selected |
| ir_eff | output | 4 | Instruction passed on to the chip's decoder |
| ir_blocked | output | 1 | The last Update-IR was filtered |
| tdo_out | output | 1 | Gated serial data toward the TDO pin |
| prot_level | output | 2 | Current protection level, 0 = P1 to 3 = P4 |
| auth_locked | output | 1 | Failure limit reached; lowering the level is disabled |

## Verification
`ir_eff` and `ir_blocked` are due one rising edge after the cycle in which `tap_update_ir` is high. `prot_level` and `auth_locked` are due one rising edge after the Update-DR cycle. `tdo_out` responds to `dr_tdo_in` within the same cycle, through the registered level and instruction. The bench changes inputs one nanosecond after each falling edge. It compares every output with its behavioural model at the falling edge, before the new inputs are applied, so each value is read after exactly the register stage that produces it. Its directed checks read the outputs in the idle cycle that follows each Update pulse.

// File: rtl/jag_pkg.sv
package jag_pkg;

  typedef enum logic [2:0] {
    CL_BYP  = 3'd0,
    CL_ID   = 3'd1,
    CL_BSC  = 3'd2,
    CL_DBG  = 3'd3,
    CL_FLS  = 3'd4,
    CL_AUTH = 3'd5,
    CL_BAD  = 3'd6
  } icls_t;

  localparam int NCLS = 5;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_P1 = 2'd0;
  localparam lvl_t LVL_P2 = 2'd1;
  localparam lvl_t LVL_P3 = 2'd2;
  localparam lvl_t LVL_P4 = 2'd3;

  // table row per level, one bit per class (bit index = class code)
  localparam logic [4*NCLS-1:0] PERM_DEFAULT =
    {5'b00001, 5'b00111, 5'b11001, 5'b11111};

  function automatic logic lvl_allows(input logic [4*NCLS-1:0] tbl,
                                      input lvl_t lv, input icls_t c);
    logic ok;
    if (c == CL_AUTH)     ok = 1'b1;
    else if (c == CL_BAD) ok = 1'b0;
    else                  ok = tbl[int'(lv) * NCLS + int'(c)];
    return ok;
  endfunction

endpackage

// File: rtl/jag_ir_filter.sv
module jag_ir_filter
  import jag_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] OP_BYPASS = '1,
  parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(1),
  parameter logic [IR_W-1:0] OP_EXTEST = IR_W'(0),
  parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(2),
  parameter logic [IR_W-1:0] OP_AUTH   = IR_W'(7),
  parameter int DBG_BASE = 8,
  parameter int DBG_CNT  = 4,
  parameter int FLS_BASE = 12,
  parameter int FLS_CNT  = 2,
  parameter logic [4*NCLS-1:0] PERM_TBL = PERM_DEFAULT
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            upd_ir,
  input  logic [IR_W-1:0] ir_in,
  input  lvl_t            level,
  output logic [IR_W-1:0] ir_eff,
  output logic            blocked,
  output icls_t           eff_cls
);

  function automatic icls_t classify(input logic [IR_W-1:0] op);
    icls_t c;
    int v;
    v = int'(op);
    if (op == OP_BYPASS)                               c = CL_BYP;
    else if (op == OP_IDCODE)                          c = CL_ID;
    else if (op == OP_EXTEST || op == OP_SAMPLE)       c = CL_BSC;
    else if (op == OP_AUTH)                            c = CL_AUTH;
    else if (v >= DBG_BASE && v < DBG_BASE + DBG_CNT)  c = CL_DBG;
    else if (v >= FLS_BASE && v < FLS_BASE + FLS_CNT)  c = CL_FLS;
    else                                               c = CL_BAD;
    return c;
  endfunction

  icls_t in_cls;
  logic  allow_now;
  logic  ev_pass;
  logic  ev_filter;

  assign in_cls    = classify(ir_in);
  assign allow_now = lvl_allows(PERM_TBL, level, in_cls);
  assign ev_pass   = upd_ir && allow_now;
  assign ev_filter = upd_ir && !allow_now;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_eff  <= OP_BYPASS;
      blocked <= 1'b0;
    end else if (ev_pass) begin
      ir_eff  <= ir_in;
      blocked <= 1'b0;
    end else if (ev_filter) begin
      ir_eff  <= OP_BYPASS;
      blocked <= 1'b1;
    end
  end

  assign eff_cls = classify(ir_eff);

  // R4: a filtered request leaves BYPASS in the instruction output
  a_r4_blocked_bypass: assert property (@(posedge tck) disable iff (!trst_n)
    blocked |-> ir_eff == OP_BYPASS);

  // R4: the instruction output only moves on an Update-IR
  a_r4_hold_between: assert property (@(posedge tck) disable iff (!trst_n)
    !$past(upd_ir) |-> $stable(ir_eff));

  // R5: the authentication code is never filtered
  a_r5_auth_passes: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(upd_ir) && classify($past(ir_in)) == CL_AUTH) |-> ir_eff == OP_AUTH);

endmodule

// File: rtl/jag_auth.sv
module jag_auth
  import jag_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hC35A,
  parameter int MAX_FAILS = 3
) (
  input  logic tck,
  input  logic trst_n,
  input  logic shift_en,
  input  logic upd_en,
  input  logic tdi,
  output lvl_t level,
  output logic locked
);

  localparam int AUTH_W = KEY_W + 2;
  localparam int FCW    = $clog2(MAX_FAILS + 1);

  // every bit is examined, so the compare takes the same path for any input
  function automatic logic key_equal(input logic [KEY_W-1:0] a,
                                     input logic [KEY_W-1:0] b);
    logic [KEY_W-1:0] diff;
    diff = a ^ b;
    return ~|diff;
  endfunction

  logic [AUTH_W-1:0] sr;
  logic [FCW-1:0]    fails;
  lvl_t              req;
  logic [KEY_W-1:0]  cred;
  logic              cred_ok;
  logic              is_lower;
  logic              ev_raise;
  logic              ev_unlock;
  logic              ev_fail;

  assign req       = sr[1:0];
  assign cred      = sr[AUTH_W-1:2];
  assign cred_ok   = key_equal(cred, KEY);
  assign is_lower  = req < level;
  assign locked    = (fails == FCW'(MAX_FAILS));
  assign ev_raise  = upd_en && !is_lower;
  assign ev_unlock = upd_en && is_lower && !locked && cred_ok;
  assign ev_fail   = upd_en && is_lower && !locked && !cred_ok;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       sr <= '0;
    else if (upd_en)   sr <= '0;
    else if (shift_en) sr <= {tdi, sr[AUTH_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                     level <= LVL_P4;
    else if (ev_raise || ev_unlock)  level <= req;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      fails <= '0;
    else if (ev_fail) fails <= fails + FCW'(1);
  end

  // R7: the level only drops after a matching credential while unlocked
  a_r7_lower_needs_key: assert property (@(posedge tck) disable iff (!trst_n)
    (level < $past(level)) |-> $past(upd_en && cred_ok && !locked));

  // R6: a request at or above the current level always takes effect
  a_r6_raise_free: assert property (@(posedge tck) disable iff (!trst_n)
    $past(upd_en && (sr[1:0] >= level)) |-> level == $past(sr[1:0]));

  // R8: failures step by one and the lockout persists until reset
  a_r8_fail_step: assert property (@(posedge tck) disable iff (!trst_n)
    (fails != $past(fails)) |-> fails == $past(fails) + FCW'(1));

  a_r8_lock_sticky: assert property (@(posedge tck) disable iff (!trst_n)
    $past(locked) |-> locked);

endmodule

// File: rtl/jag_tdo_gate.sv
module jag_tdo_gate
  import jag_pkg::*;
(
  input  icls_t eff_cls,
  input  lvl_t  level,
  input  logic  dr_tdo_in,
  output logic  tdo_out
);

  logic pass;

  assign pass    = (eff_cls != CL_AUTH) && (level != LVL_P4);
  assign tdo_out = pass & dr_tdo_in;

endmodule

// File: rtl/jtag_access_gate.sv
module jtag_access_gate
  import jag_pkg::*;
#(
  parameter int IR_W  = 4,
  parameter int KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = 16'hC35A,
  parameter int MAX_FAILS = 3,
  parameter logic [4*NCLS-1:0] PERM_TBL = PERM_DEFAULT
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tap_update_ir,
  input  logic [IR_W-1:0] ir_in,
  input  logic            tap_shift_dr,
  input  logic            tap_update_dr,
  input  logic            tdi,
  input  logic            dr_tdo_in,
  output logic [IR_W-1:0] ir_eff,
  output logic            ir_blocked,
  output logic            tdo_out,
  output logic [1:0]      prot_level,
  output logic            auth_locked
);

  icls_t eff_cls;
  lvl_t  level;
  logic  auth_sel;
  logic  auth_shift;
  logic  auth_upd;

  assign auth_sel   = (eff_cls == CL_AUTH);
  assign auth_shift = auth_sel && tap_shift_dr;
  assign auth_upd   = auth_sel && tap_update_dr;

  jag_ir_filter #(
    .IR_W     (IR_W),
    .PERM_TBL (PERM_TBL)
  ) u_filter (
    .tck     (tck),
    .trst_n  (trst_n),
    .upd_ir  (tap_update_ir),
    .ir_in   (ir_in),
    .level   (level),
    .ir_eff  (ir_eff),
    .blocked (ir_blocked),
    .eff_cls (eff_cls)
  );

  jag_auth #(
    .KEY_W     (KEY_W),
    .KEY       (KEY),
    .MAX_FAILS (MAX_FAILS)
  ) u_auth (
    .tck      (tck),
    .trst_n   (trst_n),
    .shift_en (auth_shift),
    .upd_en   (auth_upd),
    .tdi      (tdi),
    .level    (level),
    .locked   (auth_locked)
  );

  jag_tdo_gate u_tdo (
    .eff_cls   (eff_cls),
    .level     (level),
    .dr_tdo_in (dr_tdo_in),
    .tdo_out   (tdo_out)
  );

  assign prot_level = level;

  // R9: no serial data leaves the chip at the closed level
  a_r9_closed_silent: assert property (@(posedge tck) disable iff (!trst_n)
    (prot_level == LVL_P4) |-> !tdo_out);

  // R9: the authentication register never reaches the pin
  a_r9_auth_silent: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_eff == IR_W'(7)) |-> !tdo_out);

endmodule

// File: tb/jtag_access_gate_tb.sv
`timescale 1ns/1ps
module jtag_access_gate_tb;

  localparam int KW = 16;
  localparam int AW = KW + 2;
  localparam logic [KW-1:0] GOOD_KEY = 16'hC35A;
  localparam logic [KW-1:0] BAD_KEY  = 16'h1234;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tap_update_ir = 1'b0;
  logic [3:0] ir_in = 4'h0;
  logic       tap_shift_dr = 1'b0;
  logic       tap_update_dr = 1'b0;
  logic       tdi = 1'b0;
  logic       dr_tdo_in = 1'b0;
  logic [3:0] ir_eff;
  logic       ir_blocked;
  logic       tdo_out;
  logic [1:0] prot_level;
  logic       auth_locked;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 tck = ~tck;

  jtag_access_gate u_dut (
    .tck(tck), .trst_n(trst_n), .tap_update_ir(tap_update_ir), .ir_in(ir_in),
    .tap_shift_dr(tap_shift_dr), .tap_update_dr(tap_update_dr), .tdi(tdi),
    .dr_tdo_in(dr_tdo_in), .ir_eff(ir_eff), .ir_blocked(ir_blocked),
    .tdo_out(tdo_out), .prot_level(prot_level), .auth_locked(auth_locked)
  );

  // ---------------- reference model ----------------
  int m_lvl = 3;
  int m_ir = 15;
  int m_blk = 0;
  int m_fail = 0;
  bit m_q[$];

  // class number: 0 byp 1 id 2 bscan 3 debug 4 flash 5 auth 6 undefined
  function automatic int cls_of(int code);
    case (code)
      15: return 0;
      1: return 1;
      0, 2: return 2;
      8, 9, 10, 11: return 3;
      12, 13: return 4;
      7: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic bit may_run(int lv, int code);
    int c;
    c = cls_of(code);
    if (c == 5) return 1;
    if (c == 6) return 0;
    if (c == 0) return 1;
    case (lv)
      0: return 1;
      1: return (c == 3 || c == 4);
      2: return (c == 1 || c == 2);
      default: return 0;
    endcase
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      m_lvl = 3; m_ir = 15; m_blk = 0; m_fail = 0; m_q.delete();
    end else begin
      if (tap_update_dr && m_ir == 7) begin
        int req;
        int cr;
        int n;
        bit reg_b[AW];
        n = m_q.size();
        for (int i = 0; i < AW; i++) reg_b[i] = 0;
        for (int k = 0; k < n; k++) reg_b[AW - n + k] = m_q[k];
        req = reg_b[0] + 2 * reg_b[1];
        cr = 0;
        for (int i = 0; i < KW; i++) if (reg_b[i + 2]) cr += (1 << i);
        if (req >= m_lvl) m_lvl = req;
        else if (m_fail < 3) begin
          if (cr == int'(GOOD_KEY)) m_lvl = req;
          else m_fail++;
        end
        m_q.delete();
      end else if (tap_shift_dr && m_ir == 7) begin
        m_q.push_back(tdi);
        if (m_q.size() > AW) void'(m_q.pop_front());
      end
      if (tap_update_ir) begin
        if (may_run(m_lvl, int'(ir_in))) begin m_ir = int'(ir_in); m_blk = 0; end
        else begin m_ir = 15; m_blk = 1; end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge tck) begin
    if (trst_n) begin
      int exp_tdo;
      exp_tdo = (m_ir != 7 && m_lvl != 3) ? int'(dr_tdo_in) : 0;
      check(int'(ir_eff) == m_ir, "R4 model ir_eff", int'(ir_eff), m_ir);
      check(int'(ir_blocked) == m_blk, "R4 model ir_blocked", int'(ir_blocked), m_blk);
      check(int'(prot_level) == m_lvl, "R7 model level", int'(prot_level), m_lvl);
      check(int'(auth_locked) == int'(m_fail >= 3), "R8 model locked",
            int'(auth_locked), int'(m_fail >= 3));
      check(int'(tdo_out) == exp_tdo, "R9 model tdo", int'(tdo_out), exp_tdo);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input bit uir, input logic [3:0] code, input bit sh,
                     input bit udr, input bit d);
    @(negedge tck);
    #1;
    tap_update_ir = uir; ir_in = code; tap_shift_dr = sh;
    tap_update_dr = udr; tdi = d;
  endtask

  task automatic idle();
    cyc(0, 4'h0, 0, 0, 0);
  endtask

  task automatic do_ir(input logic [3:0] code);
    cyc(1, code, 0, 0, 0);
    idle();
  endtask

  task automatic do_auth(input int req, input logic [KW-1:0] key);
    logic [AW-1:0] word;
    word = {key, 2'(req)};
    do_ir(4'h7);
    for (int i = 0; i < AW; i++) cyc(0, 4'h0, 1, 0, word[i]);
    cyc(0, 4'h0, 0, 1, 0);
    idle();
  endtask

  task automatic bare_update();
    cyc(0, 4'h0, 0, 1, 0);
    idle();
  endtask

  task automatic expect_ir(input logic [3:0] code, input logic [3:0] exp, input string tag);
    do_ir(code);
    check(ir_eff == exp, tag, int'(ir_eff), int'(exp));
  endtask

  task automatic do_reset();
    @(negedge tck); #1;
    trst_n = 0;
    repeat (2) @(negedge tck);
    #1; trst_n = 1;
  endtask

  initial begin : watchdog
    forever begin
      @(posedge tck);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge tck);
    #1; trst_n = 1;
    idle();
    // R1 reset state
    check(prot_level == 2'd3, "R1 level after reset", int'(prot_level), 3);
    check(ir_eff == 4'hF, "R1 ir_eff after reset", int'(ir_eff), 15);
    check(ir_blocked == 1'b0, "R1 blocked after reset", int'(ir_blocked), 0);
    check(auth_locked == 1'b0, "R1 locked after reset", int'(auth_locked), 0);

    // R3 at P4 only bypass runs
    expect_ir(4'h1, 4'hF, "R3 P4 idcode filtered");
    check(ir_blocked == 1'b1, "R4 blocked flag set", int'(ir_blocked), 1);
    expect_ir(4'h0, 4'hF, "R3 P4 extest filtered");
    expect_ir(4'h9, 4'hF, "R3 P4 debug filtered");
    expect_ir(4'hC, 4'hF, "R3 P4 flash filtered");
    expect_ir(4'hF, 4'hF, "R3 P4 bypass runs");
    check(ir_blocked == 1'b0, "R4 blocked flag clear", int'(ir_blocked), 0);
    dr_tdo_in = 1'b1; #0.5;
    check(tdo_out == 1'b0, "R9 P4 tdo silent", int'(tdo_out), 0);

    // R5 auth code accepted at P4, R9 silent during auth
    expect_ir(4'h7, 4'h7, "R5 auth accepted at P4");
    #0.5;
    check(tdo_out == 1'b0, "R9 auth tdo silent", int'(tdo_out), 0);

    // R7 lower to P3 with key
    do_auth(2, GOOD_KEY);
    check(prot_level == 2'd2, "R7 lowered to P3", int'(prot_level), 2);
    expect_ir(4'h1, 4'h1, "R3 P3 idcode runs");
    #0.5;
    check(tdo_out == 1'b1, "R9 tdo passes at P3", int'(tdo_out), 1);
    dr_tdo_in = 1'b0; #0.5;
    check(tdo_out == 1'b0, "R9 tdo follows low", int'(tdo_out), 0);
    dr_tdo_in = 1'b1;
    expect_ir(4'h2, 4'h2, "R3 P3 sample runs");
    expect_ir(4'hA, 4'hF, "R3 P3 debug filtered");

    // R6 raise without credential
    do_auth(3, BAD_KEY);
    check(prot_level == 2'd3, "R6 raise to P4 with wrong key", int'(prot_level), 3);
    check(auth_locked == 1'b0, "R6 raise counts no failure", int'(auth_locked), 0);

    // R7 lower to P2
    do_auth(1, GOOD_KEY);
    check(prot_level == 2'd1, "R7 lowered to P2", int'(prot_level), 1);
    expect_ir(4'hB, 4'hB, "R3 P2 debug runs");
    expect_ir(4'hD, 4'hD, "R3 P2 flash runs");
    expect_ir(4'h1, 4'hF, "R3 P2 idcode filtered");
    expect_ir(4'h0, 4'hF, "R3 P2 extest filtered");

    // R7 lower to P1, R2 decode including undefined codes
    do_auth(0, GOOD_KEY);
    check(prot_level == 2'd0, "R7 lowered to P1", int'(prot_level), 0);
    expect_ir(4'h1, 4'h1, "R2 P1 idcode");
    expect_ir(4'h0, 4'h0, "R2 P1 extest");
    expect_ir(4'h8, 4'h8, "R2 P1 debug low end");
    expect_ir(4'hC, 4'hC, "R2 P1 flash low end");
    expect_ir(4'h5, 4'hF, "R2 undefined 0x5 filtered at P1");
    expect_ir(4'hE, 4'hF, "R2 undefined 0xE filtered at P1");

    // R8 failures and lockout
    do_auth(3, GOOD_KEY);
    do_auth(1, BAD_KEY);
    check(prot_level == 2'd3, "R8 fail keeps level", int'(prot_level), 3);
    check(auth_locked == 1'b0, "R8 one failure not locked", int'(auth_locked), 0);
    do_auth(1, BAD_KEY);
    check(auth_locked == 1'b0, "R8 two failures not locked", int'(auth_locked), 0);
    do_auth(0, BAD_KEY);
    check(auth_locked == 1'b1, "R8 three failures locked", int'(auth_locked), 1);
    do_auth(0, GOOD_KEY);
    check(prot_level == 2'd3, "R8 locked ignores good key", int'(prot_level), 3);
    check(auth_locked == 1'b1, "R8 lock persists", int'(auth_locked), 1);

    // R1 reset clears lockout
    do_reset();
    idle();
    check(auth_locked == 1'b0, "R1 reset clears lock", int'(auth_locked), 0);
    check(prot_level == 2'd3, "R1 reset level P4", int'(prot_level), 3);
    do_auth(2, GOOD_KEY);
    check(prot_level == 2'd2, "R7 lower works after reset", int'(prot_level), 2);

    // R10 register cleared on update: empty updates become failed lowering
    do_auth(3, GOOD_KEY);
    bare_update();
    check(prot_level == 2'd3, "R10 empty update keeps level", int'(prot_level), 3);
    bare_update();
    bare_update();
    check(auth_locked == 1'b1, "R10 cleared register yields failures", int'(auth_locked), 1);

    repeat (3) idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule